// File: doc/BRIEF.md
# Quad Latched-Reload Down-Counter

This block holds four identical 16-bit down-counters behind an 8-bit register port. Each channel keeps three pieces of state: a reload value that software builds one byte at a time, a running count that steps down on a shared prescale strobe, and an output snapshot that software reads one byte at a time. Software never touches the running count directly. A "start" command copies the reload value into the count. A "capture" command copies the count into the snapshot, so that the two byte reads of a 16-bit value come from the same instant.

When a running count is zero and a strobe arrives, the channel loads its reload value again and raises its own terminal pulse for exactly one clock. That pulse is meant to drive an interrupt status bit elsewhere. The channels share the strobe and the register port. In every other respect they are independent.

Channel n answers at the 16-byte slot whose address bits [6:4] equal 4+n. Inside a slot, offset 0x0 is the low byte and offset 0x4 the high byte of the reload value on write, and of the snapshot on read. A write of any value to offset 0x8 is a start command. A write of any value to offset 0xC is a capture command.

Top module: `tmr_quad_top`

## Requirements
- R1: A synchronous active-low reset clears every reload value, running count and snapshot to zero, drives rd_data to 0x00 and drives every terminal pulse low.
- R2: A channel is selected only when addr[6:4] is between 4 and 7, giving channel addr[6:4]-4, and addr[3:0] is 0x0, 0x4, 0x8 or 0xC. Writes to any other address change no state. A read at any address other than offsets 0x0 and 0x4 of a channel returns 0x00.
- R3: A write to offset 0x0 replaces bits 7:0 of that channel's reload value and keeps bits 15:8. A write to offset 0x4 replaces bits 15:8 and keeps bits 7:0. Neither write changes the running count.
- R4: A write of any data to offset 0x8 loads the running count with the 16-bit reload value. This takes priority over a strobe in the same cycle.
- R5: A write of any data to offset 0xC copies the running count, as it stood before that clock edge, into the snapshot. A read at offset 0x0 returns snapshot bits 7:0 and a read at offset 0x4 returns bits 15:8. rd_data is registered, holds its value between reads, and is valid the cycle after rd_en.
- R6: The snapshot changes only on a capture command. Reads and strobes leave it unchanged.
- R7: On each cycle with tick high, a non-zero running count decreases by one. Without tick or a start command, the count holds.
- R8: A strobe while the running count is zero reloads the count from the reload value. It also raises that channel's term_pulse bit (bit n for channel n) for one cycle, in the cycle after the edge.
- R9: Writes and commands addressed to one channel leave the reload value, count and snapshot of every other channel unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Shared prescale strobe, one step per high cycle |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 7 | Register byte address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| term_pulse | output | 4 | One-cycle terminal pulse per channel, bit n for channel n |

## Verification
Reload byte writes, start commands and capture commands all take effect at the clock edge that samples the write. rd_data shows a read one edge after rd_en. A terminal pulse appears in the cycle that follows the strobe edge at which the count was zero. The bench changes inputs on the falling edge, lets exactly one rising edge pass, and samples on the next falling edge. So every read result and every pulse is compared in the one cycle it is due. Pulse bits are sampled once more a cycle later to confirm they have fallen. A start command and a capture command are each issued together with a strobe, to check the priority and the pre-edge sampling.

// File: rtl/tmr_quad_pkg.sv
// Shared constants and the register offset encoding for the quad counter.
// Assumes an 8-bit register byte and 16-bit counts built from two bytes.
package tmr_quad_pkg;
    localparam int BYTE_W   = 8;
    localparam int ADDR_W   = 7;
    localparam int SLOT_W   = 3;
    localparam int OFFS_W   = 4;

    // Offset of each register inside a channel's 16-byte slot.
    localparam logic [OFFS_W-1:0] OFFS_LO   = 4'h0;
    localparam logic [OFFS_W-1:0] OFFS_HI   = 4'h4;
    localparam logic [OFFS_W-1:0] OFFS_GO   = 4'h8;
    localparam logic [OFFS_W-1:0] OFFS_SNAP = 4'hC;
endpackage

// File: rtl/tmr_quad_decode.sv
// Address decoder: turns a register access into per-channel write strobes
// and a read selection. Assumes CH_BASE + CH_COUNT <= 8 (3-bit slot field).
module tmr_quad_decode
    import tmr_quad_pkg::*;
#(
    parameter int CH_COUNT = 4,
    parameter int CH_BASE  = 4,
    localparam int IDX_W   = (CH_COUNT > 1) ? $clog2(CH_COUNT) : 1
) (
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   addr,
    output logic [CH_COUNT-1:0] wr_lo,
    output logic [CH_COUNT-1:0] wr_hi,
    output logic [CH_COUNT-1:0] wr_go,
    output logic [CH_COUNT-1:0] wr_snap,
    output logic                rd_hit,
    output logic                rd_hi,
    output logic [IDX_W-1:0]    rd_idx
);
    logic [SLOT_W-1:0] slot;
    logic [SLOT_W-1:0] rel;
    logic [OFFS_W-1:0] offs;
    logic              chan_ok;

    // Split the address into slot and offset and test the slot range.
    always_comb begin
        slot    = addr[ADDR_W-1:OFFS_W];
        offs    = addr[OFFS_W-1:0];
        rel     = slot - SLOT_W'(CH_BASE);
        chan_ok = (slot >= SLOT_W'(CH_BASE)) && (rel < SLOT_W'(CH_COUNT));
    end

    // One set of write strobes per channel.
    for (genvar i = 0; i < CH_COUNT; i++) begin : g_strobe
        logic sel;
        assign sel        = wr_en && chan_ok && (rel == SLOT_W'(i));
        assign wr_lo[i]   = sel && (offs == OFFS_LO);
        assign wr_hi[i]   = sel && (offs == OFFS_HI);
        assign wr_go[i]   = sel && (offs == OFFS_GO);
        assign wr_snap[i] = sel && (offs == OFFS_SNAP);
    end

    // Read selection: only the two snapshot bytes are readable.
    always_comb begin
        rd_hit = rd_en && chan_ok && ((offs == OFFS_LO) || (offs == OFFS_HI));
        rd_hi  = (offs == OFFS_HI);
        rd_idx = rel[IDX_W-1:0];
    end
endmodule

// File: rtl/tmr_quad_channel.sv
// One counter channel: byte-loaded reload value, running down-count driven
// by a shared strobe, capture snapshot and a one-cycle terminal pulse.
// Assumes at most one of the write strobes is high in any cycle.
module tmr_quad_channel
    import tmr_quad_pkg::*;
#(
    parameter int DATA_W  = BYTE_W,
    localparam int CNT_W  = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic              wr_go,
    input  logic              wr_snap,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CNT_W-1:0]  snap_q,
    output logic              term_pulse
);
    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] count_q;
    logic             at_zero;

    assign at_zero = (count_q == '0);

    // Reload value: replace one byte per write, keep the other.
    always_ff @(posedge clk) begin
        if (!rst_n)     reload_q <= '0;
        else if (wr_lo) reload_q <= {reload_q[CNT_W-1:DATA_W], wr_data};
        else if (wr_hi) reload_q <= {wr_data, reload_q[DATA_W-1:0]};
    end

    // Running count: start command first, then strobe-driven step or reload.
    always_ff @(posedge clk) begin
        if (!rst_n)       count_q <= '0;
        else if (wr_go)   count_q <= reload_q;
        else if (tick)    count_q <= at_zero ? reload_q : count_q - CNT_W'(1);
    end

    // Snapshot: captures the pre-edge count on a capture command only.
    always_ff @(posedge clk) begin
        if (!rst_n)        snap_q <= '0;
        else if (wr_snap)  snap_q <= count_q;
    end

    // Terminal pulse: one cycle after a strobe that found the count at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) term_pulse <= 1'b0;
        else        term_pulse <= tick && !wr_go && at_zero;
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (reload_q == '0) && (count_q == '0) && (snap_q == '0) && !term_pulse);

    a_r3_lo_keeps_hi: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> (reload_q[DATA_W-1:0] == $past(wr_data))
               && (reload_q[CNT_W-1:DATA_W] == $past(reload_q[CNT_W-1:DATA_W])));

    a_r3_hi_keeps_lo: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi |=> (reload_q[CNT_W-1:DATA_W] == $past(wr_data))
               && (reload_q[DATA_W-1:0] == $past(reload_q[DATA_W-1:0])));

    a_r3_reload_no_count: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo || wr_hi) && !tick && !wr_go |=> $stable(count_q));

    a_r4_go_loads: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go |=> count_q == $past(reload_q));

    a_r5_snap_capture: assert property (@(posedge clk) disable iff (!rst_n)
        wr_snap |=> snap_q == $past(count_q));

    a_r6_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_snap |=> $stable(snap_q));

    a_r7_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !wr_go && (count_q != '0) |=> count_q == $past(count_q) - CNT_W'(1));

    a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick && !wr_go |=> $stable(count_q));

    a_r8_zero_reload: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !wr_go && (count_q == '0) |=> term_pulse && (count_q == $past(reload_q)));

    a_r8_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
        term_pulse |-> $past(tick) && ($past(count_q) == '0));
endmodule

// File: rtl/tmr_quad_readmux.sv
// Read path: picks one snapshot byte and registers it onto rd_data.
// Unselected reads return zero. rd_data holds its value between reads.
module tmr_quad_readmux
    import tmr_quad_pkg::*;
#(
    parameter int CH_COUNT = 4,
    parameter int DATA_W   = BYTE_W,
    localparam int CNT_W   = 2 * DATA_W,
    localparam int IDX_W   = (CH_COUNT > 1) ? $clog2(CH_COUNT) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          rd_en,
    input  logic                          rd_hit,
    input  logic                          rd_hi,
    input  logic [IDX_W-1:0]              rd_idx,
    input  logic [CH_COUNT-1:0][CNT_W-1:0] snaps,
    output logic [DATA_W-1:0]             rd_data
);
    logic [CNT_W-1:0]  sel_snap;
    logic [DATA_W-1:0] sel_byte;

    // Select the addressed snapshot and byte lane.
    always_comb begin
        sel_snap = snaps[rd_idx];
        sel_byte = rd_hi ? sel_snap[CNT_W-1:DATA_W] : sel_snap[DATA_W-1:0];
    end

    // Register the byte on a read; misses read as zero.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_hit ? sel_byte : '0;
    end

    a_r2_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && !rd_hit |=> rd_data == '0);

    a_r5_low_lane: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && rd_hit && !rd_hi |=> rd_data == $past(snaps[rd_idx][DATA_W-1:0]));

    a_r5_high_lane: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && rd_hit && rd_hi |=> rd_data == $past(snaps[rd_idx][CNT_W-1:DATA_W]));

    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
endmodule

// File: rtl/tmr_quad_top.sv
// Quad latched-reload down-counter. Four channels share one byte-wide
// register port and one prescale strobe. Assumes CH_BASE + CH_COUNT <= 8.
module tmr_quad_top
    import tmr_quad_pkg::*;
#(
    parameter int CH_COUNT = 4,
    parameter int CH_BASE  = 4,
    parameter int DATA_W   = BYTE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wr_data,
    output logic [DATA_W-1:0]   rd_data,
    output logic [CH_COUNT-1:0] term_pulse
);
    localparam int CNT_W = 2 * DATA_W;
    localparam int IDX_W = (CH_COUNT > 1) ? $clog2(CH_COUNT) : 1;

    logic [CH_COUNT-1:0]            wr_lo;
    logic [CH_COUNT-1:0]            wr_hi;
    logic [CH_COUNT-1:0]            wr_go;
    logic [CH_COUNT-1:0]            wr_snap;
    logic                           rd_hit;
    logic                           rd_hi;
    logic [IDX_W-1:0]               rd_idx;
    logic [CH_COUNT-1:0][CNT_W-1:0] snaps;

    tmr_quad_decode #(
        .CH_COUNT (CH_COUNT),
        .CH_BASE  (CH_BASE)
    ) u_decode (
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (addr),
        .wr_lo   (wr_lo),
        .wr_hi   (wr_hi),
        .wr_go   (wr_go),
        .wr_snap (wr_snap),
        .rd_hit  (rd_hit),
        .rd_hi   (rd_hi),
        .rd_idx  (rd_idx)
    );

    for (genvar i = 0; i < CH_COUNT; i++) begin : g_chan
        tmr_quad_channel #(
            .DATA_W (DATA_W)
        ) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .tick       (tick),
            .wr_lo      (wr_lo[i]),
            .wr_hi      (wr_hi[i]),
            .wr_go      (wr_go[i]),
            .wr_snap    (wr_snap[i]),
            .wr_data    (wr_data),
            .snap_q     (snaps[i]),
            .term_pulse (term_pulse[i])
        );
    end

    tmr_quad_readmux #(
        .CH_COUNT (CH_COUNT),
        .DATA_W   (DATA_W)
    ) u_readmux (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .rd_hit  (rd_hit),
        .rd_hi   (rd_hi),
        .rd_idx  (rd_idx),
        .snaps   (snaps),
        .rd_data (rd_data)
    );

    a_r2_single_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_lo, wr_hi, wr_go, wr_snap}));

    a_r2_no_write_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |-> ({wr_lo, wr_hi, wr_go, wr_snap} == '0));

    a_r9_snaps_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        wr_snap == '0 |=> $stable(snaps));
endmodule

// File: tb/tmr_quad_top_test.sv
// Self-checking bench: a vector table walked by one loop, then directed
// tests for strobe priority, terminal pulses and reset.
module tmr_quad_top_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [6:0] addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [3:0] term_pulse;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    tmr_quad_top uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .addr       (addr),
        .wr_data    (wr_data),
        .rd_data    (rd_data),
        .term_pulse (term_pulse)
    );

    // Vector: {op[1:0], req[3:0], addr[6:0], data[7:0]}; op 0 write, 1 read-check, 2 tick.
    localparam int NV = 41;
    localparam logic [20:0] VECS [0:NV-1] = '{
        {2'd0, 4'd3, 7'h40, 8'h34}, {2'd0, 4'd3, 7'h44, 8'h12},   // R3 reload bytes
        {2'd0, 4'd3, 7'h4C, 8'h5A}, {2'd1, 4'd3, 7'h40, 8'h00},   // R3 count untouched
        {2'd1, 4'd3, 7'h44, 8'h00},
        {2'd0, 4'd4, 7'h48, 8'hC3}, {2'd0, 4'd5, 7'h4C, 8'h00},   // R4 start, R5 capture
        {2'd1, 4'd5, 7'h40, 8'h34}, {2'd1, 4'd5, 7'h44, 8'h12},
        {2'd2, 4'd7, 7'h00, 8'h00}, {2'd2, 4'd7, 7'h00, 8'h00},   // R7 three steps
        {2'd2, 4'd7, 7'h00, 8'h00}, {2'd0, 4'd7, 7'h4C, 8'h01},
        {2'd1, 4'd7, 7'h40, 8'h31}, {2'd1, 4'd7, 7'h44, 8'h12},
        {2'd0, 4'd3, 7'h40, 8'hFF}, {2'd0, 4'd4, 7'h48, 8'h00},   // R3 low keeps high
        {2'd0, 4'd5, 7'h4C, 8'h00}, {2'd1, 4'd3, 7'h40, 8'hFF},
        {2'd1, 4'd3, 7'h44, 8'h12},
        {2'd0, 4'd3, 7'h44, 8'hAB}, {2'd0, 4'd4, 7'h48, 8'h00},   // R3 high keeps low
        {2'd0, 4'd5, 7'h4C, 8'h00}, {2'd1, 4'd3, 7'h40, 8'hFF},
        {2'd1, 4'd3, 7'h44, 8'hAB},
        {2'd0, 4'd9, 7'h70, 8'h05}, {2'd0, 4'd9, 7'h74, 8'h00},   // R9 channel 3
        {2'd0, 4'd9, 7'h78, 8'h00}, {2'd0, 4'd9, 7'h7C, 8'h00},
        {2'd1, 4'd9, 7'h70, 8'h05}, {2'd1, 4'd9, 7'h74, 8'h00},
        {2'd1, 4'd9, 7'h40, 8'hFF}, {2'd1, 4'd9, 7'h44, 8'hAB},   // R9 channel 0 intact
        {2'd0, 4'd2, 7'h30, 8'h77}, {2'd0, 4'd2, 7'h42, 8'h99},   // R2 dead addresses
        {2'd0, 4'd2, 7'h48, 8'h00}, {2'd0, 4'd2, 7'h4C, 8'h00},
        {2'd1, 4'd2, 7'h40, 8'hFF}, {2'd1, 4'd2, 7'h44, 8'hAB},
        {2'd1, 4'd2, 7'h48, 8'h00}, {2'd1, 4'd2, 7'h30, 8'h00}
    };

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    task automatic do_write(input logic [6:0] a, input logic [7:0] d, input logic tk);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d; tick = tk;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
    endtask

    task automatic do_read(input logic [6:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        check(req, $sformatf("read %02h", a), rd_data, exp);
    endtask

    task automatic do_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1", "rd_data after reset", rd_data, 8'h00);
        check("R1", "term_pulse after reset", {4'h0, term_pulse}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            case (VECS[i][20:19])
                2'd0: do_write(VECS[i][14:8], VECS[i][7:0], 1'b0);
                2'd1: do_read(VECS[i][14:8], VECS[i][7:0], $sformatf("R%0d", VECS[i][18:15]));
                default: do_tick();
            endcase
        end

        // R6: reads and strobes leave the snapshot alone
        do_read(7'h40, 8'hFF, "R6");
        do_read(7'h40, 8'hFF, "R6");
        do_tick();
        do_read(7'h40, 8'hFF, "R6");
        do_read(7'h44, 8'hAB, "R6");

        // R8: channel 1 reload 2, zero reached, pulse on third strobe
        do_write(7'h50, 8'h02, 1'b0);
        do_write(7'h54, 8'h00, 1'b0);
        do_write(7'h58, 8'h00, 1'b0);
        do_tick();
        check("R8", "pulse1 count 1", {7'h0, term_pulse[1]}, 8'h00);
        do_tick();
        check("R8", "pulse1 count 0", {7'h0, term_pulse[1]}, 8'h00);
        do_tick();
        check("R8", "pulse1 at reload", {7'h0, term_pulse[1]}, 8'h01);
        @(negedge clk);
        check("R8", "pulse1 one cycle", {7'h0, term_pulse[1]}, 8'h00);
        do_write(7'h5C, 8'h00, 1'b0);
        do_read(7'h50, 8'h02, "R8");

        // R4: start command wins over a same-cycle strobe
        do_write(7'h50, 8'h09, 1'b0);
        do_write(7'h58, 8'h00, 1'b1);
        do_write(7'h5C, 8'h00, 1'b0);
        do_read(7'h50, 8'h09, "R4");

        // R5: capture with a strobe takes the pre-edge count
        do_write(7'h5C, 8'h00, 1'b1);
        do_read(7'h50, 8'h09, "R5");
        do_write(7'h5C, 8'h00, 1'b0);
        do_read(7'h50, 8'h08, "R5");

        // R1: reset in mid-run clears everything
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check("R1", "rd_data after mid reset", rd_data, 8'h00);
        check("R1", "term_pulse after mid reset", {4'h0, term_pulse}, 8'h00);
        do_write(7'h4C, 8'h00, 1'b0);
        do_read(7'h40, 8'h00, "R1");
        do_read(7'h44, 8'h00, "R1");
        do_write(7'h48, 8'h00, 1'b0);
        do_write(7'h4C, 8'h00, 1'b0);
        do_read(7'h44, 8'h00, "R1");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule